// File: doc/BRIEF.md
# Forwarded-Clock Lane Deserializer

This block sits behind four differential line receivers and one forwarded-clock receiver. A bit clock running at seven times the word rate samples each line once per bit time. The block rebuilds the 28-bit parallel word carried across those lines and presents it with a strobe. The rising edge of the strobe marks the cycle in which a new word becomes valid. Word boundaries come from the shape of the forwarded clock line. That line is high for the first four bit times of each word and low for the last three, so the first bit sampled high after a low bit opens a new word.

A link monitor runs alongside the datapath. After reset, or after the active-low power-down input is released, the block treats the link as settling. It discards a parameterised number of complete words, then raises its lock output and starts delivering data. While power-down is held, the word, the strobe and the lock output all read zero. If the forwarded clock stops toggling for two word periods, the block raises a clock-loss flag and keeps the last delivered word unchanged. The next rising clock-line transition clears the flag and restarts framing.

Top module: `lvds_deser_rx`

## Requirements
- R1: For data line L (0 to 3) and slot k (0 to 6), the bit sampled in slot k lands on output bit 7*L+k. Slot 0 is the first bit time in which the clock line is sampled 1 after a sample of 0. Slot k is the bit time k cycles after slot 0.
- R2: Framing depends only on where the clock line rises. A word that starts after any number of idle bit times, with the clock line held low, is still decoded correctly.
- R3: `word_o` changes only on the bit-clock edge where `strobe_o` rises. The strobe then stays high for exactly 4 bit-clock cycles.
- R4: When `pd_n_i` is sampled low, `word_o`, `strobe_o` and `locked_o` are all 0 from the next edge onward, for as long as it stays low. No strobe occurs during that time.
- R5: After reset or power-down release, the first LOCK_WORDS complete words are discarded. `locked_o` rises on the edge after the last of them completes, and no strobe occurs before that edge.
- R6: If no rising clock-line transition is seen for 14 bit samples (two word periods), `clk_lost_o` goes high. `word_o` then keeps its last value and no strobe occurs, whatever the data lines do.
- R7: A rising clock-line transition after a loss clears `clk_lost_o`. The words that follow are delivered without a new lock interval.
- R8: A rising clock-line transition in the middle of a word restarts the slot count at 0. The partial word is discarded and never strobed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Active-low power-down |
| ck_lane_i | input | 1 | Sampled forwarded-clock line |
| data_lane_i | input | 4 | Sampled data lines, one bit per bit time each |
| word_o | output | 28 | Rebuilt parallel word |
| strobe_o | output | 1 | Output strobe; rising edge marks a new valid word |
| locked_o | output | 1 | High once the settling interval has elapsed |
| clk_lost_o | output | 1 | High while the forwarded clock has stopped |

## Verification
Two situations are hard to reach from the ports: a clock-line rise that lands in the middle of a word, and a clock line that stops while the data lines keep toggling. The bench produces the first by driving four high clock-line bits followed by only one low bit before starting a fresh word. It then checks that the number of strobed words grows by exactly the number of full words sent. For the second, it holds the clock line low, randomises the data lines, and samples the loss flag on both sides of the 14-sample threshold. At the same time it confirms that the held word and the strobe count do not move.

// File: rtl/lvds_rx_pkg.sv
package lvds_rx_pkg;

    localparam int DEF_LANES      = 4;
    localparam int DEF_SLOTS      = 7;
    localparam int DEF_LOCK_WORDS = 16;
    localparam int DEF_LOSS_WORDS = 2;

    typedef enum logic {
        LK_ACQUIRE = 1'b0,
        LK_HOLD    = 1'b1
    } lock_state_e;

    // strobe high time in bit cycles: the larger half of a word period
    function automatic int strobe_len(input int slots);
        return (slots + 1) / 2;
    endfunction

endpackage

// File: rtl/lvds_rx_sampler.sv
module lvds_rx_sampler #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ck_lane_i,
    input  logic [LANES-1:0] data_lane_i,
    output logic [LANES-1:0] data_q_o,
    output logic             rise_o
);
    logic ck_q;
    logic ck_prev_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ck_q      <= 1'b0;
            ck_prev_q <= 1'b0;
            data_q_o  <= '0;
        end else begin
            ck_q      <= ck_lane_i;
            ck_prev_q <= ck_q;
            data_q_o  <= data_lane_i;
        end
    end

    assign rise_o = ck_q & ~ck_prev_q;

endmodule

// File: rtl/lvds_rx_framer.sv
module lvds_rx_framer #(
    parameter int SLOTS      = 7,
    parameter int LOSS_WORDS = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic rise_i,
    output logic frame_done_o,
    output logic no_clock_o
);
    localparam int CNT_MAX = LOSS_WORDS * SLOTS;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] since_q;
    logic [CW-1:0] pos;

    // position of the current sample relative to the last clock-line rise
    always_comb begin
        if (rise_i) begin
            pos = '0;
        end else if (since_q == CW'(CNT_MAX)) begin
            pos = CW'(CNT_MAX);
        end else begin
            pos = since_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            since_q <= CW'(CNT_MAX);
        end else begin
            since_q <= pos;
        end
    end

    assign frame_done_o = (pos == CW'(SLOTS - 1));
    assign no_clock_o   = (pos == CW'(CNT_MAX));

endmodule

// File: rtl/lvds_rx_lane.sv
module lvds_rx_lane #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             bit_i,
    output logic [SLOTS-1:0] par_o
);
    logic [SLOTS-1:0] sr_q;

    // newest bit enters at the top; after the last slot, index k holds slot k
    assign par_o = {bit_i, sr_q[SLOTS-1:1]};

    always_ff @(posedge clk) begin
        if (clr) begin
            sr_q <= '0;
        end else begin
            sr_q <= par_o;
        end
    end

endmodule

// File: rtl/lvds_rx_lockmon.sv
module lvds_rx_lockmon
    import lvds_rx_pkg::*;
#(
    parameter int LOCK_WORDS = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic frame_done_i,
    output logic locked_o
);
    localparam int LW = (LOCK_WORDS < 2) ? 1 : $clog2(LOCK_WORDS);

    lock_state_e   state_q;
    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= LK_ACQUIRE;
            cnt_q   <= '0;
        end else if (state_q == LK_ACQUIRE && frame_done_i) begin
            if (cnt_q == LW'(LOCK_WORDS - 1)) begin
                state_q <= LK_HOLD;
            end else begin
                cnt_q <= cnt_q + LW'(1);
            end
        end
    end

    assign locked_o = (state_q == LK_HOLD);

endmodule

// File: rtl/lvds_deser_rx.sv
module lvds_deser_rx
    import lvds_rx_pkg::*;
#(
    parameter int LANES      = DEF_LANES,
    parameter int SLOTS      = DEF_SLOTS,
    parameter int LOCK_WORDS = DEF_LOCK_WORDS,
    parameter int LOSS_WORDS = DEF_LOSS_WORDS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pd_n_i,
    input  logic                     ck_lane_i,
    input  logic [LANES-1:0]         data_lane_i,
    output logic [LANES*SLOTS-1:0]   word_o,
    output logic                     strobe_o,
    output logic                     locked_o,
    output logic                     clk_lost_o
);
    localparam int WORD_W = LANES * SLOTS;
    localparam int STB_HI = strobe_len(SLOTS);
    localparam int SW     = $clog2(STB_HI + 1);

    logic               clr;
    logic [LANES-1:0]   data_q;
    logic               rise;
    logic               frame_done;
    logic               no_clock;
    logic               lock_int;
    logic               capture;
    logic [WORD_W-1:0]  word_next;
    logic [WORD_W-1:0]  word_q;
    logic               strobe_q;
    logic [SW-1:0]      hold_q;
    logic               lost_q;

    // power-down behaves as a synchronous clear of all state
    assign clr = rst | ~pd_n_i;

    lvds_rx_sampler #(.LANES(LANES)) u_smp (
        .clk         (clk),
        .clr         (clr),
        .ck_lane_i   (ck_lane_i),
        .data_lane_i (data_lane_i),
        .data_q_o    (data_q),
        .rise_o      (rise)
    );

    lvds_rx_framer #(.SLOTS(SLOTS), .LOSS_WORDS(LOSS_WORDS)) u_frm (
        .clk          (clk),
        .clr          (clr),
        .rise_i       (rise),
        .frame_done_o (frame_done),
        .no_clock_o   (no_clock)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        lvds_rx_lane #(.SLOTS(SLOTS)) u_lane (
            .clk   (clk),
            .clr   (clr),
            .bit_i (data_q[L]),
            .par_o (word_next[L*SLOTS +: SLOTS])
        );
    end

    lvds_rx_lockmon #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk          (clk),
        .clr          (clr),
        .frame_done_i (frame_done),
        .locked_o     (lock_int)
    );

    assign capture = frame_done & lock_int;

    always_ff @(posedge clk) begin
        if (clr) begin
            word_q   <= '0;
            strobe_q <= 1'b0;
            hold_q   <= '0;
            lost_q   <= 1'b0;
        end else begin
            lost_q <= no_clock;
            if (capture) begin
                word_q   <= word_next;
                strobe_q <= 1'b1;
                hold_q   <= SW'(STB_HI - 1);
            end else if (hold_q != '0) begin
                hold_q <= hold_q - SW'(1);
            end else begin
                strobe_q <= 1'b0;
            end
        end
    end

    assign word_o     = word_q;
    assign strobe_o   = strobe_q;
    assign locked_o   = lock_int;
    assign clk_lost_o = lost_q;

endmodule

// File: rtl/lvds_rx_checker.sv
module lvds_rx_checker #(
    parameter int WORD_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              pd_n_i,
    input logic [WORD_W-1:0] word_o,
    input logic              strobe_o,
    input logic              locked_o,
    input logic              clk_lost_o
);
    AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !pd_n_i |=> (word_o == '0) && !strobe_o && !locked_o); // R4

    AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> locked_o); // R5

    AST_WORD_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($past(pd_n_i) && !$rose(strobe_o)) |-> $stable(word_o)); // R3

    AST_STROBE_NOT_SINGLE: assert property (@(posedge clk) disable iff (rst || !pd_n_i)
        $rose(strobe_o) |=> strobe_o); // R3

    AST_LOST_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        clk_lost_o |-> !$rose(strobe_o)); // R6

endmodule

bind lvds_deser_rx lvds_rx_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pd_n_i     (pd_n_i),
    .word_o     (word_o),
    .strobe_o   (strobe_o),
    .locked_o   (locked_o),
    .clk_lost_o (clk_lost_o)
);

// File: tb/lvds_deser_rx_tb.sv
`timescale 1ns/1ps
module lvds_deser_rx_tb;
    localparam int LANES = 4;
    localparam int SLOTS = 7;
    localparam int LOCKW = 4;
    localparam int WW    = LANES * SLOTS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pd_n = 1'b1;
    logic             ck_lane = 1'b0;
    logic [LANES-1:0] data_lane = '0;
    logic [WW-1:0]    word;
    logic             strobe, locked, lost;

    int checks = 0;
    int fails  = 0;

    logic [WW-1:0] cap [0:255];
    int            cap_n = 0;
    logic          stb_prev = 1'b0;
    int            hi_run = 0;
    int            last_width = 0;
    logic [WW-1:0] sent [0:15];

    always #5 clk = ~clk;

    lvds_deser_rx #(.LOCK_WORDS(LOCKW)) u_dut (
        .clk(clk), .rst(rst), .pd_n_i(pd_n), .ck_lane_i(ck_lane),
        .data_lane_i(data_lane), .word_o(word), .strobe_o(strobe),
        .locked_o(locked), .clk_lost_o(lost)
    );

    // capture monitor: records the word present at every strobe rise
    always @(posedge clk) begin
        #1;
        if (strobe && !stb_prev) begin
            cap[cap_n[7:0]] = word;
            cap_n++;
            hi_run = 1;
        end else if (strobe) begin
            hi_run++;
        end else if (stb_prev) begin
            last_width = hi_run;
        end
        stb_prev = strobe;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic ck, input logic [LANES-1:0] d);
        @(negedge clk);
        ck_lane   = ck;
        data_lane = d;
    endtask

    task automatic send_word(input logic [WW-1:0] w);
        for (int k = 0; k < SLOTS; k++) begin
            logic [LANES-1:0] d;
            for (int l = 0; l < LANES; l++) d[l] = w[l*SLOTS + k];
            drive_bit(k < 4, d);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b0, LANES'($urandom));
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        check(word == '0, "R4 reset word", 32'(word), 0);
        check(!strobe, "R4 reset strobe", 32'(strobe), 0);
        check(!locked, "R5 reset lock", 32'(locked), 0);
    endtask

    task automatic t_lock;
        int base;
        base = cap_n;
        for (int i = 0; i < LOCKW - 1; i++) send_word(WW'($urandom));
        idle(1);
        check(!locked, "R5 lock early", 32'(locked), 0);
        send_word(WW'($urandom));
        idle(1);
        check(locked, "R5 lock rises", 32'(locked), 1);
        check(cap_n == base, "R5 no strobe before lock", 32'(cap_n - base), 0);
    endtask

    task automatic t_mapping;
        int base;
        base = cap_n;
        sent[0] = WW'(1) << 13;
        sent[1] = WW'(1) << 21;
        sent[2] = WW'(1) << 0;
        sent[3] = WW'(1) << 27;
        for (int i = 4; i < 8; i++) sent[i] = WW'($urandom);
        for (int i = 0; i < 8; i++) send_word(sent[i]);
        idle(2);
        check(cap_n - base == 8, "R1 word count", 32'(cap_n - base), 8);
        for (int i = 0; i < 8; i++)
            check(cap[(base + i) % 256] == sent[i], "R1 bit mapping", 32'(cap[(base + i) % 256]), 32'(sent[i]));
        check(last_width == 4, "R3 strobe width", 32'(last_width), 4);
    endtask

    task automatic t_offset;
        int base;
        base = cap_n;
        for (int i = 0; i < 4; i++) begin
            sent[i] = WW'($urandom);
            idle(i + 1);
            send_word(sent[i]);
        end
        idle(2);
        check(cap_n - base == 4, "R2 count after gaps", 32'(cap_n - base), 4);
        for (int i = 0; i < 4; i++)
            check(cap[(base + i) % 256] == sent[i], "R2 aligned word", 32'(cap[(base + i) % 256]), 32'(sent[i]));
    endtask

    task automatic t_midframe;
        int base;
        base = cap_n;
        for (int k = 0; k < 5; k++) drive_bit(k < 4, LANES'($urandom));
        sent[0] = WW'($urandom);
        sent[1] = WW'($urandom);
        send_word(sent[0]);
        send_word(sent[1]);
        idle(2);
        check(cap_n - base == 2, "R8 partial dropped", 32'(cap_n - base), 2);
        check(cap[base % 256] == sent[0], "R8 realigned word", 32'(cap[base % 256]), 32'(sent[0]));
    endtask

    task automatic t_loss;
        int base;
        logic [WW-1:0] last;
        last = WW'($urandom);
        send_word(last);
        base = cap_n + 1;
        idle(5);
        check(!lost, "R6 not lost yet", 32'(lost), 0);
        idle(10);
        check(lost, "R6 lost flagged", 32'(lost), 1);
        check(word == last, "R6 word held", 32'(word), 32'(last));
        idle(20);
        check(cap_n == base, "R6 no strobe while lost", 32'(cap_n), 32'(base));
        check(word == last, "R6 word still held", 32'(word), 32'(last));
    endtask

    task automatic t_recover;
        int base;
        base = cap_n;
        sent[0] = WW'($urandom);
        sent[1] = WW'($urandom);
        send_word(sent[0]);
        send_word(sent[1]);
        idle(1);
        check(!lost, "R7 loss cleared", 32'(lost), 0);
        check(cap_n - base == 2, "R7 resumed", 32'(cap_n - base), 2);
        check(cap[(base + 1) % 256] == sent[1], "R7 data", 32'(cap[(base + 1) % 256]), 32'(sent[1]));
    endtask

    task automatic t_powerdown;
        int base;
        send_word(WW'($urandom));
        @(negedge clk);
        pd_n = 1'b0;
        @(posedge clk); #2;
        base = cap_n;
        check(word == '0, "R4 word low", 32'(word), 0);
        check(!strobe && !locked, "R4 strobe and lock low", {30'd0, strobe, locked}, 0);
        send_word(WW'($urandom));
        send_word(WW'($urandom));
        idle(1);
        check(word == '0 && cap_n == base, "R4 held low", 32'(word), 0);
        @(negedge clk);
        pd_n = 1'b1;
        for (int i = 0; i < LOCKW; i++) send_word(WW'($urandom));
        sent[0] = WW'($urandom);
        send_word(sent[0]);
        idle(2);
        check(cap_n - base == 1, "R5 relock discards", 32'(cap_n - base), 1);
        check(cap[base % 256] == sent[0], "R5 first after relock", 32'(cap[base % 256]), 32'(sent[0]));
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_lock();
        t_mapping();
        t_offset();
        t_midframe();
        t_loss();
        t_recover();
        t_powerdown();
        finish_run();
    end

endmodule